// File: doc/BRIEF.md
# Per-Channel Thermal Guard with Supply Lockout

This block sits between the channel request logic and the power stage drivers of an eight-channel switch array. On every clock it takes a signed junction-temperature code per channel in degrees Celsius and one supply-voltage code in 0.1 V steps. Each channel has its own over-temperature latch with hysteresis, and a shared undervoltage lockout gates all channels. The block then drives one gated enable per channel and a single active-low diagnostic flag.

Each raw comparison passes through a filter of consecutive samples before a latch may change. A latched channel restarts by itself once it has cooled, and the supply lockout releases by itself once the supply has recovered. After a restart, the channel's current request is applied again. All outputs are registered.

Top module: `thermal_guard`

## Requirements
- R1: A channel whose temperature code is 135 or more on 3 consecutive clock edges becomes tripped, and its enable is driven low from the next edge onward. A code of 134 never trips a channel.
- R2: A tripped channel whose temperature code is below 125 on 3 consecutive edges becomes untripped, and from the next edge its enable follows its request again.
- R3: While a channel is tripped, codes from 125 to 134 keep it tripped. While it is untripped, codes below 135 keep it untripped.
- R4: A channel that trips or restarts does not change the enable of any other channel.
- R5: A supply code below 105 (10.5 V) on 3 consecutive edges sets the lockout, which drives every enable low from the next edge. A code of exactly 105 does not set it.
- R6: While the lockout is set, a supply code above 110 (11.0 V) on 3 consecutive edges releases it, and the enables then follow the requests. A code of exactly 110 does not release it.
- R7: diag_n_o is low one edge after any channel is tripped or the lockout is set, and high otherwise.
- R8: Reset clears every latch and filter count, drives all enables low and drives diag_n_o high.
- R9: A run of qualifying samples shorter than 3 edges, broken by one sample that does not qualify, restarts the count and changes no state.
- R10: With no fault present, en_o bit i equals req_i bit i one edge after it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 8 | Requested on state per channel, bit i for channel i |
| temp_i | input | 80 | Signed 10-bit temperature code per channel, channel i in bits [10i+9:10i] |
| vsup_i | input | 10 | Unsigned supply code in 0.1 V units |
| en_o | output | 8 | Gated channel enables, registered |
| diag_n_o | output | 1 | Active-low common fault flag, registered |

## Verification
The bench drives the temperature and supply codes to each threshold and one step past it: 134 against 135, 124 against 125, 105 against 104, and 110 against 111. A design with an off-by-one compare would trip or release at the wrong code. It also sends runs of qualifying samples that break after two edges, which catch a filter that does not clear its count and so latches on scattered samples. While one channel is tripped, the bench checks the other channels' enables to find any fault leaking between channels. A long constrained-random phase that holds codes near every threshold compares every cycle against a model built from the requirements. This catches a wrong latency from input to enable or to diag_n_o.

// File: rtl/thermal_guard_pkg.sv
package thermal_guard_pkg;
  localparam int DEF_NCH      = 8;
  localparam int DEF_TW       = 10;
  localparam int DEF_VW       = 10;
  localparam int DEF_TRIP_C   = 135;
  localparam int DEF_RESUME_C = 125;
  localparam int DEF_UV_OFF   = 105;
  localparam int DEF_UV_ON    = 110;
  localparam int DEF_FILT     = 3;
endpackage

// File: rtl/hyst_filter.sv
// Two-state latch that toggles only after FILT consecutive samples of the
// condition that leads out of the present state.
module hyst_filter #(
  parameter int FILT = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic set_cond,
  input  logic clr_cond,
  output logic state_q
);
  localparam int CW = (FILT < 2) ? 1 : $clog2(FILT);
  localparam logic [CW-1:0] LAST = CW'(FILT - 1);

  logic [CW-1:0] cnt_q;
  logic          hit;

  assign hit = state_q ? clr_cond : set_cond;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= 1'b0;
      cnt_q   <= '0;
    end else if (hit) begin
      if (cnt_q == LAST) begin
        state_q <= ~state_q;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= '0;
    end
  end
endmodule

// File: rtl/chan_thermal.sv
module chan_thermal #(
  parameter int TW       = 10,
  parameter int TRIP_C   = 135,
  parameter int RESUME_C = 125,
  parameter int FILT     = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [TW-1:0] temp_i,
  output logic                 trip_q
);
  localparam logic signed [TW-1:0] TRIP_V   = TW'(TRIP_C);
  localparam logic signed [TW-1:0] RESUME_V = TW'(RESUME_C);

  logic hot, cool;
  assign hot  = (temp_i >= TRIP_V);
  assign cool = (temp_i < RESUME_V);

  hyst_filter #(.FILT(FILT)) u_filt (
    .clk      (clk),
    .rst      (rst),
    .set_cond (hot),
    .clr_cond (cool),
    .state_q  (trip_q)
  );
endmodule

// File: rtl/supply_uvlo.sv
module supply_uvlo #(
  parameter int VW     = 10,
  parameter int UV_OFF = 105,
  parameter int UV_ON  = 110,
  parameter int FILT   = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [VW-1:0] vsup_i,
  output logic          uv_q
);
  localparam logic [VW-1:0] OFF_V = VW'(UV_OFF);
  localparam logic [VW-1:0] ON_V  = VW'(UV_ON);

  logic low, good;
  assign low  = (vsup_i < OFF_V);
  assign good = (vsup_i > ON_V);

  hyst_filter #(.FILT(FILT)) u_filt (
    .clk      (clk),
    .rst      (rst),
    .set_cond (low),
    .clr_cond (good),
    .state_q  (uv_q)
  );
endmodule

// File: rtl/thermal_guard.sv
module thermal_guard
  import thermal_guard_pkg::*;
#(
  parameter int NCH      = DEF_NCH,
  parameter int TW       = DEF_TW,
  parameter int VW       = DEF_VW,
  parameter int TRIP_C   = DEF_TRIP_C,
  parameter int RESUME_C = DEF_RESUME_C,
  parameter int UV_OFF   = DEF_UV_OFF,
  parameter int UV_ON    = DEF_UV_ON,
  parameter int FILT     = DEF_FILT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH-1:0]    req_i,
  input  logic [NCH*TW-1:0] temp_i,
  input  logic [VW-1:0]     vsup_i,
  output logic [NCH-1:0]    en_o,
  output logic              diag_n_o
);
  logic [NCH-1:0] trip_q;
  logic           uv_q;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    chan_thermal #(
      .TW(TW), .TRIP_C(TRIP_C), .RESUME_C(RESUME_C), .FILT(FILT)
    ) u_ch (
      .clk    (clk),
      .rst    (rst),
      .temp_i ($signed(temp_i[i*TW +: TW])),
      .trip_q (trip_q[i])
    );
  end

  supply_uvlo #(
    .VW(VW), .UV_OFF(UV_OFF), .UV_ON(UV_ON), .FILT(FILT)
  ) u_uv (
    .clk    (clk),
    .rst    (rst),
    .vsup_i (vsup_i),
    .uv_q   (uv_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_o     <= '0;
      diag_n_o <= 1'b1;
    end else begin
      en_o     <= req_i & ~trip_q & {NCH{~uv_q}};
      diag_n_o <= ~((|trip_q) | uv_q);
    end
  end
endmodule

// File: rtl/thermal_guard_chk.sv
module thermal_guard_chk #(
  parameter int NCH      = 8,
  parameter int TW       = 10,
  parameter int TRIP_C   = 135,
  parameter int RESUME_C = 125
) (
  input logic              clk,
  input logic              rst,
  input logic [NCH-1:0]    req_i,
  input logic [NCH*TW-1:0] temp_i,
  input logic [NCH-1:0]    en_o,
  input logic              diag_n_o,
  input logic [NCH-1:0]    trip_q,
  input logic              uv_q
);
  localparam logic signed [TW-1:0] TRIP_V   = TW'(TRIP_C);
  localparam logic signed [TW-1:0] RESUME_V = TW'(RESUME_C);

  // R10
  en_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
    (en_o & ~$past(req_i)) == '0);

  // R5
  uv_blocks_all_chk: assert property (@(posedge clk) disable iff (rst)
    uv_q |=> (en_o == '0));

  // R7
  diag_on_fault_chk: assert property (@(posedge clk) disable iff (rst)
    ((|trip_q) || uv_q) |=> !diag_n_o);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    // R1
    trip_needs_hot_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(trip_q[i]) |-> ($signed($past(temp_i[i*TW +: TW])) >= TRIP_V));

    // R2
    resume_needs_cool_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(trip_q[i]) |-> ($signed($past(temp_i[i*TW +: TW])) < RESUME_V));

    // R1
    tripped_off_chk: assert property (@(posedge clk) disable iff (rst)
      trip_q[i] |=> !en_o[i]);
  end
endmodule

bind thermal_guard thermal_guard_chk #(
  .NCH(NCH), .TW(TW), .TRIP_C(TRIP_C), .RESUME_C(RESUME_C)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req_i    (req_i),
  .temp_i   (temp_i),
  .en_o     (en_o),
  .diag_n_o (diag_n_o),
  .trip_q   (trip_q),
  .uv_q     (uv_q)
);

// File: tb/thermal_guard_tb.sv
`timescale 1ns/1ps
module thermal_guard_tb;
  localparam int NCH = 8;
  localparam int TW  = 10;
  localparam int VW  = 10;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NCH-1:0]    req = '0;
  logic [NCH*TW-1:0] temp_bus;
  logic [VW-1:0]     vsup = VW'(240);
  logic [NCH-1:0]    en_o;
  logic              diag_n_o;

  int t [NCH];
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  always_comb
    for (int c = 0; c < NCH; c++) temp_bus[c*TW +: TW] = TW'(t[c]);

  thermal_guard u_dut (
    .clk(clk), .rst(rst), .req_i(req), .temp_i(temp_bus),
    .vsup_i(vsup), .en_o(en_o), .diag_n_o(diag_n_o)
  );

  // model of the requirements
  bit [NCH-1:0] m_trip, m_en;
  bit           m_uv, m_diag;
  int           m_cnt [NCH];
  int           m_ucnt;

  function automatic bit t_cond(bit tripped, int v);
    return tripped ? (v < 125) : (v >= 135);
  endfunction

  function automatic bit v_cond(bit locked, int v);
    return locked ? (v > 110) : (v < 105);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_trip = '0; m_uv = 0; m_en = '0; m_diag = 1; m_ucnt = 0;
      for (int c = 0; c < NCH; c++) m_cnt[c] = 0;
    end else begin
      m_en   = req & ~m_trip & {NCH{~m_uv}};
      m_diag = !((|m_trip) || m_uv);
      for (int c = 0; c < NCH; c++) begin
        if (t_cond(m_trip[c], t[c])) begin
          if (m_cnt[c] == 2) begin m_trip[c] = ~m_trip[c]; m_cnt[c] = 0; end
          else m_cnt[c]++;
        end else m_cnt[c] = 0;
      end
      if (v_cond(m_uv, int'(vsup))) begin
        if (m_ucnt == 2) begin m_uv = ~m_uv; m_ucnt = 0; end
        else m_ucnt++;
      end else m_ucnt = 0;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      total++;
      if (en_o !== m_en || diag_n_o !== m_diag) begin
        bad++;
        $display("FAIL R1 R2 R5 R6 R7 R10 model: en=%h diag=%b expected en=%h diag=%b",
                 en_o, diag_n_o, m_en, m_diag);
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    #(8ns * 200000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual=expired expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int c = 0; c < NCH; c++) t[c] = 25;
    step(3);
    rst = 1'b0;
    step(1);
    chk("R8 reset en", en_o, 0);
    chk("R8 reset diag", diag_n_o, 1);

    req = 8'hA5; step(1);
    chk("R10 follow req", en_o, 8'hA5);
    req = 8'hFF; step(1);
    chk("R10 follow req", en_o, 8'hFF);

    // R1 boundary 134 never trips
    t[2] = 134; step(5);
    chk("R1 134 no trip", en_o, 8'hFF);
    t[2] = 25;

    // R1 trip at 135 and R4 isolation
    t[0] = 135; step(3);
    chk("R1 latency before trip", en_o, 8'hFF);
    step(1);
    chk("R1 R4 tripped ch0", en_o, 8'hFE);
    chk("R7 diag low", diag_n_o, 0);

    // R3 hold inside hysteresis band
    t[0] = 130; step(5);
    chk("R3 hold at 130", en_o, 8'hFE);
    t[0] = 125; step(5);
    chk("R3 hold at 125", en_o, 8'hFE);

    // R2 restart below 125
    t[0] = 124; step(4);
    chk("R2 restart", en_o, 8'hFF);
    chk("R7 diag high", diag_n_o, 1);

    // R9 broken runs do not trip
    t[1] = 140; step(2); t[1] = 20; step(1);
    t[1] = 140; step(2); t[1] = 20; step(3);
    chk("R9 short runs", en_o, 8'hFF);

    // R5 undervoltage
    vsup = VW'(105); step(5);
    chk("R5 105 no lock", en_o, 8'hFF);
    vsup = VW'(104); step(4);
    chk("R5 lockout", en_o, 8'h00);
    chk("R7 diag uv", diag_n_o, 0);

    // R6 release
    vsup = VW'(110); step(5);
    chk("R6 110 holds", en_o, 8'h00);
    vsup = VW'(111); step(4);
    chk("R6 release", en_o, 8'hFF);
    chk("R7 diag clear", diag_n_o, 1);

    // constrained random phase near every threshold
    for (int k = 0; k < 4000; k++) begin
      if (k % 6 == 0) begin
        for (int c = 0; c < NCH; c++)
          if ($urandom_range(0, 2) == 0) t[c] = 118 + int'($urandom_range(0, 24));
        if ($urandom_range(0, 3) == 0) vsup = VW'(100 + $urandom_range(0, 15));
      end
      if ($urandom_range(0, 4) == 0) req = NCH'($urandom);
      step(1);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule